// File: doc/BRIEF.md
# Register-Mapped Serial Peripheral Master

This block is a master for a four-wire serial peripheral bus that software drives through a small bank of 32-bit registers. Registers sit on a 4-byte stride. Software writes a word to the transmit register, and the block shifts that word out MSB first while it shifts in the word returned by the slave. When the exchange finishes, the received word is held in the receive register and a ready flag is raised.

The status flags cover receive ready, transmit ready, an idle transmitter and two kinds of overrun. Each flag that can interrupt has an enable bit at the same position in the control register. The enabled flags are ORed onto a single interrupt line.

Chip selects are active low. Each line is enabled by a bit in the select mask. A selected line is driven low for the length of a transfer, or for as long as software holds the force bit. The serial clock idles low, data is sampled on its rising edge and changed on its falling edge. Each half period lasts `CLK_DIV` system clock cycles.

Top module: `spim_top`

## Requirements
- R1: After reset, status reads 0x60 (transmitter empty and transmit ready set), control, select mask and receive data read 0, every chip select is high, the serial clock is low and the interrupt is low.
- R2: Byte offsets are receive data 0, transmit data 4, status 8, control 12 and select mask 20. Control keeps only bits 3, 4, 6, 7, 8 and 10, so writing all ones reads back 0x5D8. The select mask keeps `NUM_CS` bits. Any other offset reads 0.
- R3: Each accepted write to offset 4 causes exactly one exchange of `WORD_BITS` clock pulses. The word goes out MSB first. The serial clock idles low, and each level lasts `CLK_DIV` system cycles. MISO is sampled on the rising edge and MOSI changes on the falling edge.
- R4: When an exchange completes, the received word is latched into the receive register and status bit 7 (receive ready) is set. A read of offset 0 returns the word and clears bit 7.
- R5: Status bit 6 (transmit ready) is high while the one-word transmit holding register is empty. Status bit 5 (transmitter empty) is high only when the holding register is empty and no exchange is in progress.
- R6: Status bit 3 (receive overrun) is set when an exchange completes while bit 7 is still set. The new word replaces the old one.
- R7: Status bit 4 (transmit overrun) is set when offset 4 is written while bit 6 is low. The written word is dropped and causes no exchange.
- R8: Status bit 8 is the OR of bits 3 and 4. Any write to offset 8 clears bits 3, 4 and 8.
- R9: The interrupt is high exactly when some status bit among 3, 4, 6, 7 and 8 is set and the control bit at the same position is also set.
- R10: Chip select line i is low only when select mask bit i is set and either an exchange is pending or in progress, or control bit 10 is set. Otherwise it is high.
- R11: While control bit 10 is set, the selected line stays low before, between and after exchanges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (consumes receive data at offset 0) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_CS | Active-low chip selects |

## Verification
A wrong shift count or a wrong divider shows on the serial pins within one word time, as a wrong number of clock pulses, a wrong high time or a corrupted captured word. A flag that is stuck or set at the wrong moment shows at the next status read or, if its enable bit is set, on the interrupt pin in the following cycle. A holding register that does not drain either blocks the second exchange or lets a dropped word through. Both show up as a wrong pulse count within two word times.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam logic [4:0] OFS_RXD  = 5'd0;
    localparam logic [4:0] OFS_TXD  = 5'd4;
    localparam logic [4:0] OFS_STAT = 5'd8;
    localparam logic [4:0] OFS_CTRL = 5'd12;
    localparam logic [4:0] OFS_SEL  = 5'd20;

    localparam int BIT_ROE  = 3;
    localparam int BIT_TOE  = 4;
    localparam int BIT_TMT  = 5;
    localparam int BIT_TRDY = 6;
    localparam int BIT_RRDY = 7;
    localparam int BIT_ERR  = 8;
    localparam int BIT_FCS  = 10;

    localparam logic [31:0] IRQ_MASK  = (32'd1 << BIT_ROE) | (32'd1 << BIT_TOE) |
                                        (32'd1 << BIT_TRDY) | (32'd1 << BIT_RRDY) |
                                        (32'd1 << BIT_ERR);
    localparam logic [31:0] CTRL_MASK = IRQ_MASK | (32'd1 << BIT_FCS);

    typedef struct packed {
        logic err;
        logic rrdy;
        logic trdy;
        logic tmt;
        logic toe;
        logic roe;
    } spim_flags_t;

    function automatic logic [31:0] pack_status(spim_flags_t f);
        logic [31:0] w;
        w = '0;
        w[BIT_ROE]  = f.roe;
        w[BIT_TOE]  = f.toe;
        w[BIT_TMT]  = f.tmt;
        w[BIT_TRDY] = f.trdy;
        w[BIT_RRDY] = f.rrdy;
        w[BIT_ERR]  = f.err;
        return w;
    endfunction

endpackage

// File: rtl/spim_shifter.sv
module spim_shifter #(
    parameter int WORD_BITS = 8,
    parameter int CLK_DIV   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [WORD_BITS-1:0] tx_word,
    input  logic                 miso,
    output logic                 sclk,
    output logic                 mosi,
    output logic                 busy,
    output logic                 done,
    output logic [WORD_BITS-1:0] rx_word
);
    localparam int DIV_W = $clog2(CLK_DIV + 1);
    localparam int CNT_W = $clog2(WORD_BITS + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(WORD_BITS - 1);

    logic                 phase;
    logic [DIV_W-1:0]     div_cnt;
    logic [CNT_W-1:0]     bit_cnt;
    logic [WORD_BITS-1:0] tx_sh;
    logic [WORD_BITS-1:0] rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            phase   <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy    <= 1'b1;
                phase   <= 1'b0;
                div_cnt <= '0;
                bit_cnt <= '0;
                tx_sh   <= tx_word;
            end else if (busy) begin
                if (div_cnt == DIV_LAST) begin
                    div_cnt <= '0;
                    if (!phase) begin
                        phase <= 1'b1;
                        rx_sh <= (rx_sh << 1) | WORD_BITS'(miso);
                    end else begin
                        phase <= 1'b0;
                        if (bit_cnt == BIT_LAST) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            tx_sh   <= tx_sh << 1;
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
        end
    end

    assign sclk    = busy & phase;
    assign mosi    = tx_sh[WORD_BITS-1];
    assign rx_word = rx_sh;

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy); // R3
    AST_DONE_ENDS_WORD: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !sclk); // R3

endmodule

// File: rtl/spim_flags.sv
module spim_flags
    import spim_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        done,
    input  logic        rd_rx,
    input  logic        wr_status,
    input  logic        tx_blocked,
    input  logic        hold_full,
    input  logic        busy,
    input  logic [31:0] ctrl,
    output logic [31:0] status,
    output logic        irq
);
    logic rrdy_q;
    logic roe_q;
    logic toe_q;
    spim_flags_t flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            rrdy_q <= 1'b0;
            roe_q  <= 1'b0;
            toe_q  <= 1'b0;
        end else begin
            if (done)       rrdy_q <= 1'b1;
            else if (rd_rx) rrdy_q <= 1'b0;

            if (done && rrdy_q && !rd_rx) roe_q <= 1'b1;
            else if (wr_status)           roe_q <= 1'b0;

            if (tx_blocked)     toe_q <= 1'b1;
            else if (wr_status) toe_q <= 1'b0;
        end
    end

    always_comb begin
        flags.roe  = roe_q;
        flags.toe  = toe_q;
        flags.tmt  = !hold_full && !busy;
        flags.trdy = !hold_full;
        flags.rrdy = rrdy_q;
        flags.err  = roe_q | toe_q;
    end

    assign status = pack_status(flags);
    assign irq    = |(status & ctrl & IRQ_MASK);

    AST_RRDY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> status[BIT_RRDY]); // R4
    AST_ROE_ON_LOST: assert property (@(posedge clk) disable iff (rst)
        (done && status[BIT_RRDY] && !rd_rx) |=> status[BIT_ROE]); // R6
    AST_TOE_ON_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        tx_blocked |=> status[BIT_TOE]); // R7
    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (wr_status && !done && !tx_blocked) |=> !status[BIT_ERR]); // R8

endmodule

// File: rtl/spim_cs.sv
module spim_cs #(
    parameter int NUM_CS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CS-1:0] sel,
    input  logic              active,
    input  logic              force_on,
    output logic [NUM_CS-1:0] ss_n
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        assign ss_n[i] = !(sel[i] && (active || force_on));
    end

    AST_CS_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (!active && !force_on) |-> (&ss_n)); // R10
    AST_CS_FORCED: assert property (@(posedge clk) disable iff (rst)
        force_on |-> ((~ss_n) == sel)); // R11

endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int WORD_BITS = 8,
    parameter int NUM_CS    = 16,
    parameter int CLK_DIV   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] ss_n
);
    logic [31:0]          ctrl_q;
    logic [NUM_CS-1:0]    sel_q;
    logic [WORD_BITS-1:0] hold_q;
    logic                 hold_full;
    logic [WORD_BITS-1:0] rxd_q;
    logic [31:0]          status;
    logic                 busy;
    logic                 done;
    logic                 start;
    logic [WORD_BITS-1:0] rx_word;

    logic wr_tx, wr_stat, wr_ctrl, wr_sel, rd_rx, tx_blocked;

    assign wr_tx      = bus_wr && (bus_addr == OFS_TXD);
    assign wr_stat    = bus_wr && (bus_addr == OFS_STAT);
    assign wr_ctrl    = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_sel     = bus_wr && (bus_addr == OFS_SEL);
    assign rd_rx      = bus_rd && (bus_addr == OFS_RXD);
    assign tx_blocked = wr_tx && hold_full;
    assign start      = hold_full && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            sel_q     <= '0;
            hold_q    <= '0;
            hold_full <= 1'b0;
            rxd_q     <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
            if (wr_sel)  sel_q  <= bus_wdata[NUM_CS-1:0];
            if (wr_tx && !hold_full) begin
                hold_q    <= bus_wdata[WORD_BITS-1:0];
                hold_full <= 1'b1;
            end else if (start) begin
                hold_full <= 1'b0;
            end
            if (done) rxd_q <= rx_word;
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_RXD:  bus_rdata = 32'(rxd_q);
            OFS_STAT: bus_rdata = status;
            OFS_CTRL: bus_rdata = ctrl_q;
            OFS_SEL:  bus_rdata = 32'(sel_q);
            default:  bus_rdata = '0;
        endcase
    end

    spim_shifter #(
        .WORD_BITS(WORD_BITS),
        .CLK_DIV  (CLK_DIV)
    ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .tx_word(hold_q),
        .miso   (miso),
        .sclk   (sclk),
        .mosi   (mosi),
        .busy   (busy),
        .done   (done),
        .rx_word(rx_word)
    );

    spim_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .done      (done),
        .rd_rx     (rd_rx),
        .wr_status (wr_stat),
        .tx_blocked(tx_blocked),
        .hold_full (hold_full),
        .busy      (busy),
        .ctrl      (ctrl_q),
        .status    (status),
        .irq       (irq)
    );

    spim_cs #(
        .NUM_CS(NUM_CS)
    ) u_cs (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel_q),
        .active  (busy || hold_full),
        .force_on(ctrl_q[BIT_FCS]),
        .ss_n    (ss_n)
    );

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((ctrl_q & IRQ_MASK) == '0) |-> !irq); // R9
    AST_DROP_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        tx_blocked |=> $stable(hold_q)); // R7

endmodule

// File: tb/tb_spim_top.sv
`timescale 1ns/1ps
module tb_spim_top;
    localparam int WB = 8;
    localparam int NCS = 16;
    localparam int DIV = 2;

    logic clk = 1'b0;
    logic rst;
    logic [4:0] bus_addr;
    logic bus_wr, bus_rd;
    logic [31:0] bus_wdata, bus_rdata;
    logic irq, sclk, mosi, miso;
    logic [NCS-1:0] ss_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spim_top #(.WORD_BITS(WB), .NUM_CS(NCS), .CLK_DIV(DIV)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk),
        .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    // slave model: mode 0, MSB first, wraps every WB bits
    logic [WB-1:0] slave_word = '0;
    int slave_idx = WB - 1;
    logic [WB-1:0] captured = '0;
    int rises = 0;
    int high_cycles = 0;
    assign miso = slave_word[slave_idx];
    always @(negedge sclk) slave_idx = (slave_idx == 0) ? WB - 1 : slave_idx - 1;
    always @(posedge sclk) begin
        captured = {captured[WB-2:0], mosi};
        rises++;
    end
    always @(posedge clk) if (sclk) high_cycles++;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_rrdy();
        logic [31:0] s;
        for (int i = 0; i < 1000; i++) begin
            bus_read(5'd8, s);
            if (s[7]) break;
        end
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 1000; i++) begin
            bus_read(5'd8, s);
            if (s[5]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(5'd8, d);  check("R1 status", d, 32'h60);
        bus_read(5'd12, d); check("R1 control", d, 0);
        bus_read(5'd20, d); check("R1 select", d, 0);
        bus_read(5'd0, d);  check("R1 rxdata", d, 0);
        check("R1 ss_n", 32'(ss_n), 32'hFFFF);
        check("R1 sclk", 32'(sclk), 0);
        check("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        bus_write(5'd20, 32'hFFFF_FFFF);
        bus_read(5'd20, d); check("R2 select width", d, 32'hFFFF);
        bus_write(5'd20, 0);
        bus_write(5'd12, 32'hFFFF_FFFF);
        bus_read(5'd12, d); check("R2 control bits", d, 32'h5D8);
        check("R9 irq on trdy", 32'(irq), 1);
        bus_write(5'd12, 32'h20);
        #1 check("R9 tmt has no enable", 32'(irq), 0);
        bus_write(5'd12, 0);
        bus_read(5'd16, d); check("R2 unmapped", d, 0);
        bus_read(5'd4, d);  check("R2 txdata reads zero", d, 0);
    endtask

    task automatic t_xfer(logic [7:0] tx, logic [7:0] sw);
        logic [31:0] d;
        slave_word = sw;
        bus_write(5'd20, 32'h8);
        rises = 0; high_cycles = 0;
        bus_write(5'd4, 32'(tx));
        #1 check("R10 cs low in transfer", 32'(ss_n), 32'hFFF7);
        bus_read(5'd8, d); check("R5 tmt low while busy", 32'(d[5]), 0);
        wait_rrdy();
        check("R3 pulse count", rises, WB);
        check("R3 high time", high_cycles, WB * DIV);
        check("R3 mosi word", 32'(captured), 32'(tx));
        bus_read(5'd8, d); check("R4 rrdy set", d, 32'hE0);
        check("R10 cs released", 32'(ss_n), 32'hFFFF);
        bus_read(5'd0, d); check("R4 rx word", d, 32'(sw));
        bus_read(5'd8, d); check("R4 rrdy cleared", d, 32'h60);
        bus_write(5'd20, 0);
    endtask

    task automatic t_rx_overrun();
        logic [31:0] d;
        slave_word = 8'h11;
        bus_write(5'd4, 32'h01);
        wait_rrdy();
        slave_word = 8'h22;
        bus_write(5'd4, 32'h02);
        wait_idle();
        repeat (2) @(negedge clk);
        bus_read(5'd8, d); check("R6 roe set", d, 32'h1E8);
        bus_read(5'd0, d); check("R6 newest word kept", d, 32'h22);
        bus_write(5'd8, 0);
        bus_read(5'd8, d); check("R8 clear errors", d, 32'h60);
    endtask

    task automatic t_tx_overrun();
        logic [31:0] d;
        slave_word = 8'h5A;
        bus_write(5'd12, 32'h10);
        rises = 0;
        bus_write(5'd4, 32'hC1);
        repeat (2) @(negedge clk);
        bus_read(5'd8, d); check("R5 trdy back, tmt low", d, 32'h40);
        bus_write(5'd4, 32'hC2);
        bus_read(5'd8, d); check("R5 trdy low when held", 32'(d[6]), 0);
        check("R9 irq quiet", 32'(irq), 0);
        bus_write(5'd4, 32'hC3);
        #1 check("R9 irq on toe", 32'(irq), 1);
        bus_read(5'd8, d); check("R7 toe and err", d & 32'h118, 32'h110);
        wait_idle();
        repeat (2) @(negedge clk);
        check("R7 dropped word not sent", rises, 2 * WB);
        check("R7 last word sent", 32'(captured), 32'hC2);
        bus_write(5'd8, 0);
        #1 check("R8 irq after clear", 32'(irq), 0);
        bus_read(5'd0, d);
        bus_write(5'd12, 0);
    endtask

    task automatic t_force();
        logic [31:0] d;
        bus_write(5'd20, 32'h1);
        #1 check("R10 unforced idle high", 32'(ss_n), 32'hFFFF);
        bus_write(5'd12, 32'h480);
        #1 check("R11 forced low", 32'(ss_n), 32'hFFFE);
        slave_word = 8'h3C;
        bus_write(5'd4, 32'h99);
        wait_rrdy();
        check("R9 irq on rrdy", 32'(irq), 1);
        check("R11 held after word", 32'(ss_n), 32'hFFFE);
        bus_read(5'd0, d);
        #1 check("R9 irq cleared by read", 32'(irq), 0);
        bus_write(5'd12, 0);
        #1 check("R11 release", 32'(ss_n), 32'hFFFF);
        bus_write(5'd20, 0);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_regs();
        t_xfer(8'h3C, 8'hA5);
        t_xfer(8'h81, 8'h7E);
        t_rx_overrun();
        t_tx_overrun();
        t_force();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule